// File: doc/BRIEF.md
# Programmable Character Clock Generator

This block turns a dot clock into a character clock for a text display pipeline. A small up-counter runs from a start value to its all-ones terminal state. In that last state a ripple-carry strobe is active, and on the next edge the counter reloads the start value instead of wrapping. The start value picks the character width: a narrow mode gives 8 dot states per character and a wide mode gives 10.

Three more signals come from the same counter. An active-low load pulse marks the first dot state of each character, and the dot shifter uses it to take in a new pattern. The character clock is high for the first half of each character period. A copy of the character clock is delayed by a set number of dot states, so that downstream strobes can start partway through a character and still end at the next character clock rise.

Top module: `ccg_char_clock`

## Requirements
- R1: While `rst_n` is low, the outputs are `rc_n`=0, `load_n`=1, `char_clk`=0 and `char_clk_dly`=0. The first dot edge after release starts a new character.
- R2: With `mode_narrow`=0 (wide mode), the counter reloads 6 and one character lasts 10 dot states.
- R3: With `mode_narrow`=1 (narrow mode), the counter reloads 8 and one character lasts 8 dot states.
- R4: `rc_n` is low in exactly the last dot state of each character and high in every other state.
- R5: `load_n` is low for exactly one dot state, the first state of each character, which directly follows the state where `rc_n` was low.
- R6: `char_clk` is high in the first half of each character (5 states wide, 4 states narrow) and low in the rest.
- R7: `char_clk_dly` equals `char_clk` delayed by `DLY` dot states (default 1). It reads 0 for the first states after reset.
- R8: `mode_narrow` is sampled only on the reload edge. A change during a character leaves the length of that character unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_dot | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_narrow | input | 1 | 1 = 8 dots per character, 0 = 10 dots per character |
| char_clk | output | 1 | Character clock, high for the first half of a character |
| load_n | output | 1 | Active-low one-state load pulse for the dot shifter |
| rc_n | output | 1 | Active-low ripple carry, marks the terminal state |
| char_clk_dly | output | 1 | Character clock delayed by DLY dot states |

## Verification
`rc_n` and `char_clk` are decoded from the counter, so they change at the same edge as the counter. `load_n` comes one edge after the state in which `rc_n` was low, and `char_clk_dly` comes `DLY` edges after `char_clk`. A new mode value is used only at the reload edge that follows it. The bench keeps its own phase and period model and advances it once per rising edge, using the mode value it drove before that edge. It compares all four outputs at the falling edge, which is half a period away from any change, and only then drives the next mode value. It also measures the spacing between load pulses against the period that the model expects.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  // Dot states per character for a given counter width and reload value.
  function automatic int ccg_period(input int cw, input int start);
    return (1 << cw) - start;
  endfunction
endpackage

// File: rtl/ccg_count.sv
module ccg_count #(
  parameter int CW      = 4,
  parameter int START_W = 6,
  parameter int START_N = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_narrow,
  output logic [CW-1:0] cnt_q,
  output logic          narrow_q,
  output logic          term
);
  localparam logic [CW-1:0] TERM = {CW{1'b1}};
  localparam logic [CW-1:0] LD_W = CW'(START_W);
  localparam logic [CW-1:0] LD_N = CW'(START_N);

  logic [CW-1:0] cnt_d;
  logic          narrow_d;
  logic          narrow_en;

  assign term      = (cnt_q == TERM);
  assign narrow_en = term;

  always_comb begin
    cnt_d    = cnt_q + CW'(1);
    narrow_d = narrow_q;
    if (term) begin
      cnt_d = mode_narrow ? LD_N : LD_W;
    end
    if (narrow_en) begin
      narrow_d = mode_narrow;
    end
  end

  // Reset parks the counter in the terminal state, so the first edge after release reloads.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= TERM;
      narrow_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      narrow_q <= narrow_d;
    end
  end
endmodule

// File: rtl/ccg_strobe.sv
module ccg_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic term,
  output logic load_n
);
  logic load_n_d;

  // Goes low on the reload edge; the next edge sets it high again.
  assign load_n_d = ~term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_n <= 1'b1;
    end else begin
      load_n <= load_n_d;
    end
  end
endmodule

// File: rtl/ccg_delay.sv
module ccg_delay #(
  parameter int DLY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  generate
    if (DLY == 0) begin : g_pass
      assign dout = din;
    end else begin : g_shift
      logic [DLY-1:0] sr_q;
      logic [DLY-1:0] sr_d;

      always_comb begin
        sr_d[0] = din;
        for (int i = 1; i < DLY; i++) begin
          sr_d[i] = sr_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr_q <= '0;
        end else begin
          sr_q <= sr_d;
        end
      end

      assign dout = sr_q[DLY-1];
    end
  endgenerate
endmodule

// File: rtl/ccg_char_clock.sv
module ccg_char_clock #(
  parameter int CW      = 4,
  parameter int START_W = 6,
  parameter int START_N = 8,
  parameter int DLY     = 1
) (
  input  logic clk_dot,
  input  logic rst_n,
  input  logic mode_narrow,
  output logic char_clk,
  output logic load_n,
  output logic rc_n,
  output logic char_clk_dly
);
  import ccg_pkg::*;

  localparam int            PER_W  = ccg_period(CW, START_W);
  localparam int            PER_N  = ccg_period(CW, START_N);
  localparam logic [CW-1:0] HALF_W = CW'(PER_W / 2);
  localparam logic [CW-1:0] HALF_N = CW'(PER_N / 2);
  localparam logic [CW-1:0] LD_W   = CW'(START_W);
  localparam logic [CW-1:0] LD_N   = CW'(START_N);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] offset;
  logic          narrow_q;
  logic          term;

  ccg_count #(.CW(CW), .START_W(START_W), .START_N(START_N)) u_count (
    .clk         (clk_dot),
    .rst_n       (rst_n),
    .mode_narrow (mode_narrow),
    .cnt_q       (cnt_q),
    .narrow_q    (narrow_q),
    .term        (term)
  );

  ccg_strobe u_strobe (
    .clk    (clk_dot),
    .rst_n  (rst_n),
    .term   (term),
    .load_n (load_n)
  );

  // Position inside the running character, measured from its own reload value.
  always_comb begin
    offset   = cnt_q - (narrow_q ? LD_N : LD_W);
    char_clk = narrow_q ? (offset < HALF_N) : (offset < HALF_W);
  end

  assign rc_n = ~term;

  ccg_delay #(.DLY(DLY)) u_delay (
    .clk   (clk_dot),
    .rst_n (rst_n),
    .din   (char_clk),
    .dout  (char_clk_dly)
  );
endmodule

// File: rtl/ccg_char_clock_chk.sv
module ccg_char_clock_chk #(
  parameter int DLY = 1
) (
  input logic clk_dot,
  input logic rst_n,
  input logic char_clk,
  input logic load_n,
  input logic rc_n,
  input logic char_clk_dly
);
  logic [3:0] since_rst;

  always_ff @(posedge clk_dot or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
    end else if (since_rst != 4'hF) begin
      since_rst <= since_rst + 4'd1;
    end
  end

  AST_LOAD_AFTER_RC: assert property (@(posedge clk_dot) disable iff (!rst_n)
    !rc_n |=> !load_n); // R5
  AST_LOAD_ONE_STATE: assert property (@(posedge clk_dot) disable iff (!rst_n)
    !load_n |=> load_n); // R5
  AST_RC_ONE_STATE: assert property (@(posedge clk_dot) disable iff (!rst_n)
    !rc_n |=> rc_n); // R4
  AST_CLK_RISE_AT_LOAD: assert property (@(posedge clk_dot) disable iff (!rst_n)
    $rose(char_clk) |-> !load_n); // R6
  AST_CLK_LOW_AT_TERM: assert property (@(posedge clk_dot) disable iff (!rst_n)
    !rc_n |-> !char_clk); // R6

  generate
    if (DLY == 1) begin : g_dly1
      AST_DLY_TRACKS: assert property (@(posedge clk_dot) disable iff (!rst_n)
        (since_rst >= 4'd1) |-> (char_clk_dly == $past(char_clk))); // R7
    end
  endgenerate
endmodule

bind ccg_char_clock ccg_char_clock_chk #(.DLY(DLY)) u_chk (
  .clk_dot      (clk_dot),
  .rst_n        (rst_n),
  .char_clk     (char_clk),
  .load_n       (load_n),
  .rc_n         (rc_n),
  .char_clk_dly (char_clk_dly)
);

// File: tb/sim_ccg_char_clock.sv
module sim_ccg_char_clock;
  logic clk_dot = 1'b0;
  logic rst_n;
  logic mode_narrow;
  logic char_clk, load_n, rc_n, char_clk_dly;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model: phase within character, period of current character.
  int p, per, last_per, gap;
  bit prev_cc, seen_load;

  always #4 clk_dot = ~clk_dot; // 125 MHz

  ccg_char_clock u0 (
    .clk_dot      (clk_dot),
    .rst_n        (rst_n),
    .mode_narrow  (mode_narrow),
    .char_clk     (char_clk),
    .load_n       (load_n),
    .rc_n         (rc_n),
    .char_clk_dly (char_clk_dly)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (phase %0d period %0d)", tag, what, act, exp, p, per);
    end
  endtask

  task automatic model_reset();
    per = 10; p = 9; prev_cc = 1'b0; seen_load = 1'b0; gap = 0; last_per = 10;
  endtask

  // Compare all outputs against the model; called at the falling edge.
  task automatic check_all(input string ph);
    bit exp_cc;
    exp_cc = (p < per / 2);
    check((ph == "") ? "R4" : ph, "rc_n",   rc_n,   (p == per - 1) ? 1'b0 : 1'b1);
    check((ph == "") ? "R5" : ph, "load_n", load_n, (p == 0) ? 1'b0 : 1'b1);
    check((ph == "") ? "R6" : ph, "char_clk", char_clk, exp_cc);
    check("R7", "char_clk_dly", char_clk_dly, prev_cc);
    gap++;
    if (!load_n) begin
      if (seen_load) begin
        checks++;
        if (gap != last_per) begin
          fails++;
          $display("FAIL %s period: actual %0d expected %0d", (last_per == 10) ? "R2" : "R3", gap, last_per);
        end
      end
      seen_load = 1'b1;
      gap = 0;
    end
  endtask

  task automatic model_edge();
    prev_cc = (p < per / 2);
    p++;
    if (p == per) begin
      p = 0;
      last_per = per;
      per = mode_narrow ? 8 : 10;
    end
  endtask

  task automatic run(input int n, input int kind, input string ph);
    for (int c = 0; c < n; c++) begin
      @(negedge clk_dot);
      check_all(ph);
      case (kind)
        0: mode_narrow = 1'b0;
        1: mode_narrow = 1'b1;
        2: mode_narrow = ((c / 3) % 2) == 1;
        default: mode_narrow = (((c * 7) / 5) % 2) == 1;
      endcase
      @(posedge clk_dot);
      model_edge();
    end
  endtask

  initial begin
    rst_n = 1'b0;
    mode_narrow = 1'b0;
    model_reset();
    repeat (3) @(posedge clk_dot);
    @(negedge clk_dot);
    // R1: reset state
    check("R1", "rc_n",   rc_n,   1'b0);
    check("R1", "load_n", load_n, 1'b1);
    check("R1", "char_clk", char_clk, 1'b0);
    check("R1", "char_clk_dly", char_clk_dly, 1'b0);
    rst_n = 1'b1;
    @(posedge clk_dot);
    model_edge();
    run(60, 0, "R2");
    run(60, 1, "R3");
    run(120, 2, "R8");
    run(150, 3, "R8");
    // Mid-run reset with narrow mode selected (R1)
    @(negedge clk_dot);
    rst_n = 1'b0;
    mode_narrow = 1'b1;
    model_reset();
    @(negedge clk_dot);
    check("R1", "rc_n",   rc_n,   1'b0);
    check("R1", "load_n", load_n, 1'b1);
    check("R1", "char_clk", char_clk, 1'b0);
    check("R1", "char_clk_dly", char_clk_dly, 1'b0);
    rst_n = 1'b1;
    @(posedge clk_dot);
    model_edge();
    run(60, 1, "R3");
    run(40, 0, "");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule